// File: doc/BRIEF.md
# Memory Scrub Scheduler

This block paces the background scrub cycles of an error-corrected memory. A free-running interval timer, clocked from a fixed 20 MHz reference, fires once every power-of-two number of cycles chosen by a rate code. On each expiry the block raises `busy` to warn the host. After a programmable lead time of whole clock cycles it issues a one-cycle `scrub_start` strobe to the scrub engine. It keeps `busy` high until the engine reports `scrub_done`.

A 9-bit setting is loaded from the address lines during a configuration access. The same access path, with the direction bit on the address set, copies the stored setting onto the data bus. The setting selects the rate, the lead time and a level output that tells the memory data path to bypass error correction.

When the timer expires while a scrub is still running, the request is remembered and the next scrub follows the current one without `busy` dropping. The scrub data path, the code and the array are outside this block.

Top module: `scrub_sched`

## Requirements
- R1: After reset the rate code is 7, the lead code is 10 and the bypass bit is 0, so readback gives 0x0A7, `busy`, `scrub_start` and `bypass` are 0, and the first `busy` rise comes 128 cycles after the last reset edge.
- R2: With rate code n (addr[3:0] on a write), the interval timer expires every 2^n cycles for every n from 0 to 15. While the scrubs finish in time, `busy` rises exactly 2^n, 2·2^n, 3·2^n cycles after the write edge.
- R3: With lead code k (addr[7:4] on a write), `scrub_start` is high exactly k cycles after the edge on which `busy` rises. With k = 0 it is high on that same edge.
- R4: `scrub_start` is never high for two cycles in a row, and it is only high while `busy` is high.
- R5: `busy` stays high from its rise until the edge that samples `scrub_done` in a cycle after the strobe. It falls on that edge when no request is pending.
- R6: An expiry that occurs while `busy` is high is kept as pending. On the edge that accepts `scrub_done`, `busy` stays high and a new lead period of k cycles starts, as for a fresh expiry.
- R7: Several expiries during one scrub merge into a single pending request, which yields exactly one extra scrub.
- R8: A configuration write restarts the interval timer, so the first expiry comes one full new period after the write edge.
- R9: `bypass` equals bit 8 of the last written setting (1 = error correction bypassed).
- R10: An access with addr[9] = 1 places the stored setting on data_out[8:0], with all higher data bits 0, from the next edge on. It holds until the next read and leaves the setting unchanged, whatever the other address bits carry. An access with addr[9] = 0 writes addr[8:0].
- R11: `scrub_done` while idle or during the lead period is ignored: it neither raises nor lowers `busy`, nor moves the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_access | input | 1 | Configuration access strobe, one cycle per access |
| addr | input | 10 | Address lines: [9] direction (1 = read), [8:0] setting on a write |
| scrub_done | input | 1 | Scrub engine finished the current scrub |
| data_out | output | 32 | Readback of the stored setting |
| busy | output | 1 | Host warning, scrub imminent or in progress |
| scrub_start | output | 1 | One-cycle strobe that starts a scrub |
| bypass | output | 1 | Error-correction bypass level |

## Verification
The hardest situation to reach from the ports is a timer expiry that lands while a scrub is still underway, and more so several of them that must merge into one follow-up scrub. The bench programs a two-cycle period with a five-cycle lead, so that three expiries fall inside the first scrub. It then rewrites the setting to the slowest rate just after the strobe, which silences the timer. It withholds `scrub_done` until it chooses, so exactly one extra scrub may appear, on a cycle it can predict. Back-to-back operation is also driven at rate code 0, where every cycle expires.

// File: rtl/scrub_sched_pkg.sv
// Package: field widths, reset values and shared types of the scrub scheduler.
// Assumes the setting is packed as {bypass, lead, rate} from the MSB down.
package scrub_sched_pkg;
    localparam int RATE_W = 4;
    localparam int LEAD_W = 4;
    localparam int CFG_W  = RATE_W + LEAD_W + 1;

    localparam logic [RATE_W-1:0] RATE_RST = RATE_W'(7);
    localparam logic [LEAD_W-1:0] LEAD_RST = LEAD_W'(10);

    typedef struct packed {
        logic              bypass;
        logic [LEAD_W-1:0] lead;
        logic [RATE_W-1:0] rate;
    } scrub_cfg_t;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_LEAD   = 2'd1,
        SQ_ACTIVE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/scrub_cfg_reg.sv
// Configuration register: a write access loads the setting from the address
// lines, a read access copies it to the data bus.
// Assumes addr[CFG_W] is the direction bit and ADDR_W == CFG_W + 1.
module scrub_cfg_reg
    import scrub_sched_pkg::*;
#(
    parameter int ADDR_W = CFG_W + 1,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_access,
    input  logic [ADDR_W-1:0] addr,
    output scrub_cfg_t        cfg,
    output logic              cfg_wr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DIR_BIT = CFG_W;
    localparam int PAD_W   = DATA_W - CFG_W;

    logic is_read;
    logic cfg_rd;

    // Decode the access direction from the address.
    always_comb begin
        is_read = addr[DIR_BIT];
        cfg_wr  = cfg_access && !is_read;
        cfg_rd  = cfg_access && is_read;
    end

    // Hold the setting; reload it from the address lines on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.bypass <= 1'b0;
            cfg.lead   <= LEAD_RST;
            cfg.rate   <= RATE_RST;
        end else if (cfg_wr) begin
            cfg <= scrub_cfg_t'(addr[CFG_W-1:0]);
        end
    end

    // Capture the setting onto the data bus on a read, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (cfg_rd) begin
            rd_data <= {{PAD_W{1'b0}}, cfg};
        end
    end

    // R10: a read access leaves the stored setting untouched.
    a_r10_read_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |=> $stable(cfg));
endmodule

// File: rtl/scrub_interval_timer.sv
// Interval timer: issues a one-cycle tick every 2^rate clock cycles.
// Assumes rate only changes together with restart, which clears the count.
module scrub_interval_timer #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = (1 << RATE_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Terminal count is 2^rate - 1, built as a low mask of rate ones.
    always_comb begin
        last = ~({CNT_W{1'b1}} << rate);
        tick = (cnt == last) && !restart;
    end

    // Count cycles of the period; wrap at the terminal count or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || cnt == last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: the count never runs past the terminal value of the active rate.
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);
endmodule

// File: rtl/scrub_sequencer.sv
// Scrub sequencer: raises busy on a timer tick, counts the lead time, strobes
// scrub_start, waits for scrub_done, and serves one merged pending request.
// Assumes scrub_done is only meaningful after the strobe of the current scrub.
module scrub_sequencer
    import scrub_sched_pkg::*;
#(
    parameter int LW = LEAD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [LW-1:0] lead,
    input  logic          scrub_done,
    output logic          busy,
    output logic          scrub_start
);
    seq_state_e    state;
    logic [LW-1:0] lead_cnt;
    logic          pending;
    logic          done_ok;
    logic          lead_zero;

    // Completion counts only in the active phase and never on the strobe cycle.
    always_comb begin
        done_ok   = (state == SQ_ACTIVE) && scrub_done && !scrub_start;
        lead_zero = (lead == '0);
    end

    // Main sequence: idle, lead-time countdown, active scrub.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SQ_IDLE;
            busy        <= 1'b0;
            scrub_start <= 1'b0;
            pending     <= 1'b0;
            lead_cnt    <= '0;
        end else begin
            scrub_start <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (tick) begin
                        busy <= 1'b1;
                        if (lead_zero) begin
                            scrub_start <= 1'b1;
                            state       <= SQ_ACTIVE;
                        end else begin
                            lead_cnt <= lead;
                            state    <= SQ_LEAD;
                        end
                    end
                end
                SQ_LEAD: begin
                    if (tick) pending <= 1'b1;
                    if (lead_cnt == LW'(1)) begin
                        scrub_start <= 1'b1;
                        state       <= SQ_ACTIVE;
                    end else begin
                        lead_cnt <= lead_cnt - 1'b1;
                    end
                end
                SQ_ACTIVE: begin
                    if (done_ok) begin
                        if (pending || tick) begin
                            pending <= 1'b0;
                            if (lead_zero) begin
                                scrub_start <= 1'b1;
                            end else begin
                                lead_cnt <= lead;
                                state    <= SQ_LEAD;
                            end
                        end else begin
                            busy  <= 1'b0;
                            state <= SQ_IDLE;
                        end
                    end else if (tick) begin
                        pending <= 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R4: the strobe lasts a single cycle.
    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_start |=> !scrub_start);
    // R4: the strobe only appears under busy.
    a_r4_start_under_busy: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_start |-> busy);
    // R5: busy only drops after a completion was presented.
    a_r5_busy_falls_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(scrub_done));
    // R3: a zero lead strobes on the edge that raises busy.
    a_r3_zero_lead: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && ($past(lead) == '0)) |-> scrub_start);
    // R6: a completion with a request pending keeps busy high.
    a_r6_pending_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && pending) |=> busy);
    // R11: a completion while idle changes nothing.
    a_r11_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == SQ_IDLE) && scrub_done && !tick) |=> (!busy && !scrub_start));
endmodule

// File: rtl/scrub_sched.sv
// Scrub scheduler top: configuration register, interval timer and sequencer.
// Assumes a 20 MHz clk so one lead step equals one clock cycle.
module scrub_sched
    import scrub_sched_pkg::*;
#(
    parameter int ADDR_W = CFG_W + 1,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_access,
    input  logic [ADDR_W-1:0] addr,
    input  logic              scrub_done,
    output logic [DATA_W-1:0] data_out,
    output logic              busy,
    output logic              scrub_start,
    output logic              bypass
);
    scrub_cfg_t cfg;
    logic       cfg_wr;
    logic       tick;

    scrub_cfg_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_access (cfg_access),
        .addr       (addr),
        .cfg        (cfg),
        .cfg_wr     (cfg_wr),
        .rd_data    (data_out)
    );

    scrub_interval_timer #(
        .RATE_W (RATE_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_wr),
        .rate    (cfg.rate),
        .tick    (tick)
    );

    scrub_sequencer #(
        .LW (LEAD_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .lead        (cfg.lead),
        .scrub_done  (scrub_done),
        .busy        (busy),
        .scrub_start (scrub_start)
    );

    // Bypass level comes straight from the stored setting.
    always_comb bypass = cfg.bypass;

    // R9: a write makes bypass follow the written bit 8 on the next cycle.
    a_r9_bypass_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_access && !addr[CFG_W]) |=> (bypass == $past(addr[CFG_W-1])));
endmodule

// File: tb/scrub_sched_bench.sv
// Directed bench for scrub_sched: one task per scenario, each checking itself.
module scrub_sched_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_access = 1'b0;
    logic [9:0]  addr = '0;
    logic        man_done = 1'b0;
    logic        auto_pulse = 1'b0;
    logic        scrub_done;
    logic [31:0] data_out;
    logic        busy;
    logic        scrub_start;
    logic        bypass;

    assign scrub_done = man_done | auto_pulse;

    scrub_sched u_scrub_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_access  (cfg_access),
        .addr        (addr),
        .scrub_done  (scrub_done),
        .data_out    (data_out),
        .busy        (busy),
        .scrub_start (scrub_start),
        .bypass      (bypass)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    int rise_t[8];
    int start_t[8];
    int fall_t[8];
    int nrise = 0, nstart = 0, nfall = 0, double_start = 0;
    int auto_lat = 0, dcnt = 0;
    logic busy_q = 1'b0, start_q = 1'b0;

    // Monitor and automatic completion responder, away from the active edge.
    always @(negedge clk) begin
        auto_pulse = 1'b0;
        if (dcnt > 0) begin
            dcnt--;
            if (dcnt == 0) auto_pulse = 1'b1;
        end
        if (scrub_start === 1'b1 && auto_lat > 0) dcnt = auto_lat;
        if (busy === 1'b1 && !busy_q) begin
            if (nrise < 8) rise_t[nrise] = cyc;
            nrise++;
        end
        if (busy === 1'b0 && busy_q) begin
            if (nfall < 8) fall_t[nfall] = cyc;
            nfall++;
        end
        if (scrub_start === 1'b1) begin
            if (nstart < 8) start_t[nstart] = cyc;
            nstart++;
            if (start_q) double_start++;
        end
        busy_q  = (busy === 1'b1);
        start_q = (scrub_start === 1'b1);
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) step();
    endtask

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        nrise = 0; nstart = 0; nfall = 0; double_start = 0;
    endtask

    task automatic cfg_write(input logic byp, input int lead, input int rate, output int w);
        cfg_access = 1'b1;
        addr = {1'b0, byp, 4'(lead), 4'(rate)};
        step();
        cfg_access = 1'b0;
        addr = '0;
        w = cyc;
    endtask

    task automatic cfg_read(input logic [8:0] low, output int val);
        cfg_access = 1'b1;
        addr = {1'b1, low};
        step();
        cfg_access = 1'b0;
        addr = '0;
        val = int'(data_out);
    endtask

    task automatic pulse_done();
        man_done = 1'b1;
        step();
        man_done = 1'b0;
    endtask

    // R1, R10: reset values and default timing.
    task automatic t_reset(input int last_rst);
        int v;
        check_eq("R1", "busy after reset", int'(busy), 0);
        check_eq("R1", "scrub_start after reset", int'(scrub_start), 0);
        check_eq("R1", "bypass after reset", int'(bypass), 0);
        auto_lat = 2;
        cfg_read(9'h000, v);
        check_eq("R1", "default readback", v, 32'h0A7);
        wait_to(last_rst + 142);
        check_eq("R1", "default first busy rise", rise_t[0], last_rst + 128);
        check_eq("R1", "default lead", start_t[0], last_rst + 138);
        auto_lat = 0;
    endtask

    // R2, R3, R4, R5, R8: periodic scrubs at a given rate and lead.
    task automatic t_rate(input int rate, input int lead);
        int w, w2;
        int p = 1 << rate;
        clear_mon();
        auto_lat = 2;
        cfg_write(1'b0, lead, rate, w);
        wait_to(w + 3 * p + lead + 4);
        check_eq("R2", "rise count", nrise, 3);
        check_eq("R8", "first rise after write", rise_t[0], w + p);
        for (int k = 0; k < 3; k++) begin
            check_eq("R2", "busy rise", rise_t[k], w + (k + 1) * p);
            check_eq("R3", "lead cycles", start_t[k] - rise_t[k], lead);
            check_eq("R5", "busy fall", fall_t[k], start_t[k] + 3);
        end
        check_eq("R4", "double-wide strobes", double_start, 0);
        cfg_write(1'b0, 0, 15, w2);
        auto_lat = 0;
    endtask

    // R2, R3, R6: rate code 0 expires every cycle, zero lead.
    task automatic t_rate0();
        int w, w2;
        clear_mon();
        auto_lat = 1;
        cfg_write(1'b0, 0, 0, w);
        wait_to(w + 6);
        check_eq("R2", "rate 0 first rise", rise_t[0], w + 1);
        check_eq("R3", "zero lead strobe with busy", start_t[0], w + 1);
        check_eq("R6", "back-to-back second strobe", start_t[1], w + 3);
        check_eq("R6", "busy never fell", nfall, 0);
        check_eq("R4", "double-wide strobes", double_start, 0);
        cfg_write(1'b0, 0, 15, w2);
        for (int i = 0; i < 30; i++) if (busy === 1'b1) step();
        check_eq("R5", "busy low after draining", int'(busy), 0);
        auto_lat = 0;
    endtask

    // R2: slowest rate code is still generated exactly.
    task automatic t_rate15();
        int w, w2;
        clear_mon();
        auto_lat = 2;
        cfg_write(1'b0, 0, 15, w);
        wait_to(w + 32767);
        check_eq("R2", "no rise before 2^15", nrise, 0);
        wait_to(w + 32772);
        check_eq("R2", "rate 15 rise", rise_t[0], w + 32768);
        check_eq("R5", "busy low after scrub", int'(busy), 0);
        cfg_write(1'b0, 0, 15, w2);
        auto_lat = 0;
    endtask

    // R6, R7: expiries during a scrub merge into one follow-up scrub.
    task automatic t_pending();
        int w, w2;
        clear_mon();
        auto_lat = 0;
        cfg_write(1'b0, 5, 1, w);
        wait_to(w + 8);
        check_eq("R3", "first strobe", start_t[0], w + 7);
        cfg_write(1'b0, 5, 15, w2);
        wait_to(w + 10);
        pulse_done();
        wait_to(w + 15);
        check_eq("R7", "no early second strobe", nstart, 1);
        check_eq("R6", "busy held over pending", int'(busy), 1);
        wait_to(w + 16);
        check_eq("R6", "pending strobe after lead", start_t[1], w + 16);
        check_eq("R6", "busy never fell", nfall, 0);
        wait_to(w + 17);
        pulse_done();
        check_eq("R7", "busy low after single extra scrub", int'(busy), 0);
        check_eq("R5", "busy fall cycle", fall_t[0], w + 18);
        wait_to(w + 40);
        check_eq("R7", "total strobes", nstart, 2);
    endtask

    // R11, R5: completion outside the active phase is ignored.
    task automatic t_done_ignored();
        int w, w2;
        clear_mon();
        auto_lat = 0;
        cfg_write(1'b0, 10, 5, w);
        wait_to(w + 5);
        pulse_done();
        step();
        check_eq("R11", "idle done keeps busy low", int'(busy), 0);
        check_eq("R11", "idle done gives no strobe", nstart, 0);
        wait_to(w + 34);
        pulse_done();
        step();
        check_eq("R11", "lead done keeps busy", int'(busy), 1);
        wait_to(w + 43);
        check_eq("R11", "strobe position unchanged", start_t[0], w + 42);
        check_eq("R5", "busy held until done", int'(busy), 1);
        wait_to(w + 44);
        pulse_done();
        check_eq("R5", "busy falls on done", int'(busy), 0);
        check_eq("R5", "fall cycle", fall_t[0], w + 45);
        cfg_write(1'b0, 0, 15, w2);
    endtask

    // R8: rewriting the setting restarts the period.
    task automatic t_restart();
        int w1, w2, w3;
        clear_mon();
        auto_lat = 2;
        cfg_write(1'b0, 0, 6, w1);
        wait_to(w1 + 40);
        cfg_write(1'b0, 0, 6, w2);
        wait_to(w1 + 66);
        check_eq("R8", "old period suppressed", nrise, 0);
        wait_to(w2 + 64);
        check_eq("R8", "rise one full period after rewrite", rise_t[0], w2 + 64);
        wait_to(w2 + 70);
        cfg_write(1'b0, 0, 15, w3);
        auto_lat = 0;
    endtask

    // R9, R10: bypass level and readback.
    task automatic t_bypass_readback();
        int w, v;
        cfg_write(1'b1, 5, 9, w);
        check_eq("R9", "bypass set", int'(bypass), 1);
        cfg_read(9'h000, v);
        check_eq("R10", "readback value", v, 32'h159);
        cfg_read(9'h1FF, v);
        check_eq("R10", "read with ones leaves setting", v, 32'h159);
        step();
        check_eq("R10", "readback holds", int'(data_out), 32'h159);
        check_eq("R9", "bypass kept over reads", int'(bypass), 1);
        cfg_write(1'b0, 5, 15, w);
        check_eq("R9", "bypass cleared", int'(bypass), 0);
        cfg_read(9'h000, v);
        check_eq("R10", "readback after clear", v, 32'h05F);
    endtask

    logic finished = 1'b0;

    initial begin
        int last_rst;
        repeat (3) step();
        rst_n = 1'b1;
        last_rst = cyc;
        t_reset(last_rst);
        t_bypass_readback();
        t_rate(3, 0);
        t_rate(4, 3);
        t_rate(5, 15);
        t_rate(6, 10);
        t_rate0();
        t_pending();
        t_done_ignored();
        t_restart();
        t_rate15();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run finished got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule